// File: doc/BRIEF.md
# DMA Channel Transfer Counter

This block keeps the transfer count for one DMA channel of the classic single-byte-port kind. It holds two 16-bit registers. The base count is a shadow copy that the host loads. The current count is live and moves down by one for each completed transfer. The host reaches both through one 8-bit data port. A byte-pointer flip-flop chooses which byte a host access lands on, and each access flips it. A separate clear strobe parks the pointer on the low byte, so software can begin a two-byte sequence from a known state.

A host write loads the chosen byte into both registers at once. A host read returns the chosen byte of the current count. The channel performs one more transfer than the value programmed. On the transfer that takes the current count from 0000h to FFFFh, the block emits a one-cycle terminal-count pulse. The next step depends on the auto-initialize input:
- When it is set, the current count is reloaded from the base count and the channel stays active.
- When it is clear, the channel goes idle and ignores transfer pulses until the host writes the count again.

The counting is the same whether one unit is a byte or a 16-bit word.

Top module: `dmacnt_unit`

## Requirements
- R1: After a synchronous active-low reset, both counts are 0000h, the byte pointer selects the low byte, `chan_active` is 0 and `tc_pulse` is 0.
- R2: A host write stores `host_wdata` into the selected byte (pointer 0 = bits 7:0, pointer 1 = bits 15:8) of both the base and the current count. From the next cycle on it sets `chan_active` to 1.
- R3: While `host_rd` is high, `host_rdata` shows the selected byte of the current count and never the base count.
- R4: Each host read or write flips the byte pointer at the clock edge. `ptr_clr` forces the pointer to the low byte, and it wins over an access in the same cycle. That access still uses the pointer value it saw.
- R5: A `xfer_done` pulse while the channel is active decrements the current count by one.
- R6: With a programmed count N, the terminal count comes on transfer N+1. `tc_pulse` is high for exactly the one cycle in which the current count first shows the result of the wrap from 0000h.
- R7: With `auto_init` high at the terminal transfer, the current count is reloaded from the base count and `chan_active` stays 1.
- R8: With `auto_init` low at the terminal transfer, the current count becomes FFFFh and `chan_active` drops to 0. After that, `xfer_done` changes nothing and raises no `tc_pulse` until the next host write.
- R9: When a host write and `xfer_done` arrive in the same cycle, the write takes effect and the decrement is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_rd | input | 1 | Host read strobe, one byte per cycle |
| host_wdata | input | 8 | Host write byte |
| ptr_clr | input | 1 | Forces the byte pointer to the low byte |
| xfer_done | input | 1 | One completed transfer |
| auto_init | input | 1 | Reload from base at terminal count when high |
| host_rdata | output | 8 | Selected byte of the current count |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| chan_active | output | 1 | Channel accepts transfers |

## Verification
The transfer count is driven with programmed values 0000h, 0004h, 00FFh, 0100h and 0321h, each in both auto-initialize settings. Each value probes a different part of the counter:
- 0000h and 0004h pin down the off-by-one rule.
- 00FFh and 0100h tell a carry or borrow across the byte boundary from a count that stays in the low byte.
- The larger value exercises both bytes of the counter over a long run.

The register read after terminal count shows whether the design reloaded from the base count or stopped at FFFFh. Directed cases cover the following:
- a read partway through a count, where base and current differ;
- a clear that collides with a read;
- a write that collides with a transfer;
- transfer pulses that arrive while the channel is idle.

// File: rtl/dmacnt_pkg.sv
// Package: shared widths and helpers for the DMA transfer counter.
// Assumes the count width is a whole multiple of the host byte width.
package dmacnt_pkg;
    localparam int unsigned DEF_CNT_W  = 16;
    localparam int unsigned DEF_BYTE_W = 8;

    // Byte lanes in a count register of the given widths.
    function automatic int unsigned lanes(input int unsigned cnt_w, input int unsigned byte_w);
        return cnt_w / byte_w;
    endfunction
endpackage

// File: rtl/dmacnt_byteptr.sv
// Module: byte-pointer flip-flop for host access to a wide register.
// Steps to the next byte lane on each host access and wraps after the last lane.
// An explicit clear parks it on lane 0, and the clear beats a same-cycle access.
// Assumes NBYTES >= 2.
module dmacnt_byteptr #(
    parameter int unsigned NBYTES = 2,
    localparam int unsigned PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access,
    input  logic             clr,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

    logic [PTR_W-1:0] ptr_q;

    // Pointer update: reset or clear to lane 0, otherwise step on each access.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr_q <= '0;
        end else if (access) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/dmacnt_countreg.sv
// Module: base and current count registers.
// A host write loads one byte lane into both registers.
// The current register also decrements (wrapping 0 to all-ones) or reloads from the base.
// Assumes the write, decrement and reload enables are mutually exclusive (the
// controller guarantees this).
module dmacnt_countreg #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned NBYTES = CNT_W / BYTE_W,
    localparam int unsigned PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_lane,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              dec_en,
    input  logic              reload_en,
    output logic [CNT_W-1:0]  base,
    output logic [CNT_W-1:0]  cur
);
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] cur_q;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        localparam logic [PTR_W-1:0] LANE = PTR_W'(g);
        logic hit;
        assign hit = wr_en && (wr_lane == LANE);

        // Base lane: takes the host byte when this lane is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g*BYTE_W +: BYTE_W] <= '0;
            end else if (hit) begin
                base_q[g*BYTE_W +: BYTE_W] <= wr_byte;
            end
        end

        // Current lane: host byte first, else reload or decrement.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_q[g*BYTE_W +: BYTE_W] <= '0;
            end else if (hit) begin
                cur_q[g*BYTE_W +: BYTE_W] <= wr_byte;
            end else if (!wr_en && reload_en) begin
                cur_q[g*BYTE_W +: BYTE_W] <= base_q[g*BYTE_W +: BYTE_W];
            end else if (!wr_en && dec_en) begin
                cur_q[g*BYTE_W +: BYTE_W] <= cur_dec[g*BYTE_W +: BYTE_W];
            end
        end
    end

    logic [CNT_W-1:0] cur_dec;
    assign cur_dec = cur_q - 1'b1;

    assign base = base_q;
    assign cur  = cur_q;
endmodule

// File: rtl/dmacnt_ctrl.sv
// Module: transfer acceptance, terminal count and channel-active control.
// Accepts a transfer only while the channel is active and no host write is pending.
// Detects the wrap from zero and decides between reload and idle.
// Assumes cur_zero reflects the current count in the same cycle.
module dmacnt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr,
    input  logic xfer_done,
    input  logic auto_init,
    input  logic cur_zero,
    output logic dec_en,
    output logic reload_en,
    output logic tc_pulse,
    output logic chan_active
);
    logic active_q;
    logic tc_q;
    logic accept;
    logic at_tc;

    // Decode: the write wins the cycle; the terminal transfer is an accepted one at zero.
    always_comb begin
        accept    = xfer_done && active_q && !host_wr;
        at_tc     = accept && cur_zero;
        reload_en = at_tc && auto_init;
        dec_en    = accept && !reload_en;
    end

    // Active flag: set by a host write, cleared by a terminal count without reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (host_wr) begin
            active_q <= 1'b1;
        end else if (at_tc && !auto_init) begin
            active_q <= 1'b0;
        end
    end

    // Terminal-count pulse: registered with the same edge that updates the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q <= 1'b0;
        end else begin
            tc_q <= at_tc;
        end
    end

    assign tc_pulse    = tc_q;
    assign chan_active = active_q;
endmodule

// File: rtl/dmacnt_unit.sv
// Module: top of the DMA channel transfer counter.
// Joins the byte pointer, the count registers and the controller.
// Reads return the selected byte of the current count from combinational logic.
// Assumes host_wr and host_rd are never high in the same cycle.
module dmacnt_unit #(
    parameter int unsigned CNT_W  = dmacnt_pkg::DEF_CNT_W,
    parameter int unsigned BYTE_W = dmacnt_pkg::DEF_BYTE_W,
    localparam int unsigned NBYTES = dmacnt_pkg::lanes(CNT_W, BYTE_W),
    localparam int unsigned PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              ptr_clr,
    input  logic              xfer_done,
    input  logic              auto_init,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              tc_pulse,
    output logic              chan_active
);
    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] cur_q;
    logic             dec_en;
    logic             reload_en;
    logic             cur_zero;

    dmacnt_byteptr #(.NBYTES(NBYTES)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .access (host_wr || host_rd),
        .clr    (ptr_clr),
        .ptr    (ptr_q)
    );

    dmacnt_countreg #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr),
        .wr_lane   (ptr_q),
        .wr_byte   (host_wdata),
        .dec_en    (dec_en),
        .reload_en (reload_en),
        .base      (base_q),
        .cur       (cur_q)
    );

    assign cur_zero = (cur_q == '0);

    dmacnt_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .xfer_done   (xfer_done),
        .auto_init   (auto_init),
        .cur_zero    (cur_zero),
        .dec_en      (dec_en),
        .reload_en   (reload_en),
        .tc_pulse    (tc_pulse),
        .chan_active (chan_active)
    );

    // Read mux: selected byte lane of the current count.
    always_comb begin
        host_rdata = cur_q[ptr_q*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/dmacnt_unit_chk.sv
// Module: assertion checker bound into dmacnt_unit.
// Observes ports and internal registers only; drives nothing.
module dmacnt_unit_chk #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned PTR_W  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [BYTE_W-1:0] host_wdata,
    input logic              ptr_clr,
    input logic              xfer_done,
    input logic              auto_init,
    input logic              tc_pulse,
    input logic              chan_active,
    input logic [PTR_W-1:0]  ptr_q,
    input logic [CNT_W-1:0]  base_q,
    input logic [CNT_W-1:0]  cur_q
);
    logic              seen_wr;
    logic [PTR_W-1:0]  seen_lane;
    logic [BYTE_W-1:0] seen_byte;

    // Record the last write for the copy check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_wr   <= 1'b0;
            seen_lane <= '0;
            seen_byte <= '0;
        end else begin
            seen_wr   <= host_wr;
            seen_lane <= ptr_q;
            seen_byte <= host_wdata;
        end
    end

    assert_wr_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_wr |-> (cur_q[seen_lane*BYTE_W +: BYTE_W] == seen_byte) &&
                    (base_q[seen_lane*BYTE_W +: BYTE_W] == seen_byte));

    assert_wr_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> chan_active);

    assert_ptr_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> (ptr_q == '0));

    assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && chan_active && !host_wr && cur_q != '0) |=> (cur_q == $past(cur_q) - 1'b1));

    assert_tc_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && chan_active && !host_wr && cur_q == '0) |=> tc_pulse);

    assert_tc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && chan_active && !host_wr && cur_q == '0 && auto_init)
        |=> (cur_q == $past(base_q)) && chan_active);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_active && !host_wr) |=> $stable(cur_q) && !tc_pulse);

    assert_wr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && xfer_done) |=> !tc_pulse);
endmodule

bind dmacnt_unit dmacnt_unit_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .ptr_clr     (ptr_clr),
    .xfer_done   (xfer_done),
    .auto_init   (auto_init),
    .tc_pulse    (tc_pulse),
    .chan_active (chan_active),
    .ptr_q       (ptr_q),
    .base_q      (base_q),
    .cur_q       (cur_q)
);

// File: tb/dmacnt_unit_tb.sv
module dmacnt_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       ptr_clr = 1'b0;
    logic       xfer_done = 1'b0;
    logic       auto_init = 1'b0;
    logic [7:0] host_rdata;
    logic       tc_pulse;
    logic       chan_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmacnt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .ptr_clr(ptr_clr), .xfer_done(xfer_done),
        .auto_init(auto_init), .host_rdata(host_rdata), .tc_pulse(tc_pulse),
        .chan_active(chan_active)
    );

    // Vector: programmed count, auto-init bit, expected transfers up to terminal count.
    typedef struct packed { logic [15:0] cnt; logic auto; logic [16:0] n; } vec_t;
    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0004, 1'b0, 17'd5},   '{16'h0004, 1'b1, 17'd5},
        '{16'h0000, 1'b0, 17'd1},   '{16'h0000, 1'b1, 17'd1},
        '{16'h00FF, 1'b0, 17'd256}, '{16'h00FF, 1'b1, 17'd256},
        '{16'h0100, 1'b0, 17'd257}, '{16'h0100, 1'b1, 17'd257},
        '{16'h0321, 1'b0, 17'd802}, '{16'h0321, 1'b1, 17'd802}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); host_wr = 1'b1; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic clr_ptr();
        @(negedge clk); ptr_clr = 1'b1;
        @(negedge clk); ptr_clr = 1'b0;
    endtask

    task automatic write_count(input logic [15:0] v);
        clr_ptr();
        wr_byte(v[7:0]);
        wr_byte(v[15:8]);
    endtask

    task automatic rd_byte(output logic [7:0] d);
        @(negedge clk); host_rd = 1'b1; #1 d = host_rdata;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic read_count(output logic [15:0] v);
        logic [7:0] lo, hi;
        clr_ptr();
        rd_byte(lo);
        rd_byte(hi);
        v = {hi, lo};
    endtask

    // One transfer pulse; returns tc_pulse as seen in the following cycle.
    task automatic xfer(output logic tc);
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0; tc = tc_pulse;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        logic        tc;
        int          n;

        repeat (3) @(negedge clk);
        // R1: state after reset.
        check("R1 rdata", {24'd0, host_rdata}, 32'h0);
        check("R1 active", {31'd0, chan_active}, 32'd0);
        check("R1 tc", {31'd0, tc_pulse}, 32'd0);
        rst_n = 1'b1;
        read_count(v);
        check("R1 count", {16'd0, v}, 32'h0);

        // Table walk: R2 R5 R6 R7 R8.
        for (int i = 0; i < NVEC; i++) begin
            auto_init = VECS[i].auto;
            write_count(VECS[i].cnt);
            check("R2 active after write", {31'd0, chan_active}, 32'd1);
            read_count(v);
            check("R2 readback", {16'd0, v}, {16'd0, VECS[i].cnt});
            n = 0;
            tc = 1'b0;
            while (!tc && n < 70000) begin
                xfer(tc);
                n++;
            end
            check("R6 transfer count", n, {15'd0, VECS[i].n});
            @(negedge clk);
            check("R6 tc one cycle", {31'd0, tc_pulse}, 32'd0);
            read_count(v);
            if (VECS[i].auto) begin
                check("R7 reload", {16'd0, v}, {16'd0, VECS[i].cnt});
                check("R7 stays active", {31'd0, chan_active}, 32'd1);
            end else begin
                check("R8 wrap value", {16'd0, v}, 32'hFFFF);
                check("R8 idle", {31'd0, chan_active}, 32'd0);
            end
        end

        // R8: pulses while idle are ignored.
        auto_init = 1'b0;
        write_count(16'h0000);
        xfer(tc);
        check("R8 tc at end", {31'd0, tc}, 32'd1);
        for (int k = 0; k < 3; k++) begin
            xfer(tc);
            check("R8 no tc when idle", {31'd0, tc}, 32'd0);
        end
        read_count(v);
        check("R8 count held", {16'd0, v}, 32'hFFFF);

        // R3 R5: a read mid-count returns current, not base.
        write_count(16'h0010);
        for (int k = 0; k < 3; k++) xfer(tc);
        read_count(v);
        check("R3 R5 current count", {16'd0, v}, 32'h000D);

        // R4: toggle on access; clear beats a same-cycle read.
        write_count(16'hA55A);
        clr_ptr();
        rd_byte(b);
        check("R4 low first", {24'd0, b}, 32'h5A);
        @(negedge clk); host_rd = 1'b1; ptr_clr = 1'b1; #1 b = host_rdata;
        @(negedge clk); host_rd = 1'b0; ptr_clr = 1'b0;
        check("R4 toggled to high", {24'd0, b}, 32'hA5);
        rd_byte(b);
        check("R4 clear wins", {24'd0, b}, 32'h5A);

        // R9: a write in the same cycle as a transfer wins.
        write_count(16'h0005);
        clr_ptr();
        @(negedge clk); host_wr = 1'b1; host_wdata = 8'h07; xfer_done = 1'b1;
        @(negedge clk); host_wr = 1'b0; xfer_done = 1'b0;
        check("R9 no tc", {31'd0, tc_pulse}, 32'd0);
        read_count(v);
        check("R9 write wins", {16'd0, v}, 32'h0007);

        // R1: reset in mid-run.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 active after reset", {31'd0, chan_active}, 32'd0);
        read_count(v);
        check("R1 count after reset", {16'd0, v}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule